// File: doc/BRIEF.md
# Floating-point result forwarding scoreboard

This block is the issue interlock of a floating-point pipeline in which arithmetic results arrive late and store data is consumed late. It watches one decoded instruction per cycle and decides whether that instruction may issue. For each of 16 floating-point registers it keeps a record of the youngest in-flight writer. An add runs for seven execution stages. A load, a store and a register copy each run for five. The stage that issues an instruction is not counted, so E1 is the cycle after issue.

When an instruction may issue, the block also gives the datapath a one-hot code. The code names the producer stage that will hold the operand in the cycle the consumer reads it. A store reads its data in its own E5, so a store placed directly behind the add that feeds it can issue without waiting; the value is taken from the add's pipeline instead of from the register file. An add reads its operand in E1, so it waits for the producer.

Registers are released early and allocated late:
- A newer writer takes over a register, and the write enable of the older writer is never raised. The last writer in program order therefore wins.
- A copy whose source is still in flight does not wait for the source. Its destination is bound to the same producer and commits in the same cycle.

Top module: `fp_fwd_scoreboard`

## Requirements
- R1: After reset no register is in flight: `rf_we` is zero, and an instruction whose source has never been written reads the register file.
- R2: A store (`in_op`=1) never stalls. It reads its data 5 cycles after issue, and `fwd_sel` names the producer stage in that cycle. A store one cycle behind its add gives `fwd_sel`=4'b0010 (E6).
- R3: An add (`in_op`=0) reads its source 1 cycle after issue. The result of an in-flight add can be forwarded from stage E6 onward. A dependent add therefore stalls for 4 cycles and issues 5 cycles after its producer, with `fwd_sel`=4'b0010.
- R4: A load (`in_op`=2) result can be forwarded only in its E5. An add that depends on the load stalls for 3 cycles and issues with `fwd_sel`=4'b0001.
- R5: When the source has no in-flight writer, or its writer will have committed before the read cycle, `fwd_sel`=4'b1000 (register file).
- R6: `rf_we[r]` is high for exactly one cycle. That cycle comes 7 cycles after an add to r issues, or 5 cycles after a load or an unbound copy to r issues.
- R7: A load never stalls, even when its destination has an in-flight writer. The older writer's write enable is then suppressed. In a sequence of add, then store, then load, all to the same register, only the load commits.
- R8: A copy (`in_op`=3) whose source writer has not reached its final stage issues at once with `fwd_sel` naming that writer's final stage (E7 for an add). Its destination commits in the same cycle as the source, and a later store of the destination forwards from that producer.
- R9: A bound copy stalls while a store issued earlier will still read the copy's destination from the register file after the copy's commit cycle. Once the source has reached its final stage, the copy is unbound and `fwd_sel`=4'b1000.
- R10: `issue` and `stall` are never both high, and exactly one of them is high when `in_valid` is high. An instruction that does not issue changes no state.
- R11: While `issue` is low, `fwd_sel` is zero. For an issued add or store, exactly one bit is set: bit0=E5, bit1=E6, bit2=E7, bit3=register file. An issued load gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 2 | 0 add, 1 store, 2 load, 3 copy |
| in_src | input | 4 | Source register (store data, add operand, copy source) |
| in_dst | input | 4 | Destination register (add, load, copy) |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction held this cycle |
| fwd_sel | output | 4 | One-hot operand source for the issuing instruction |
| rf_we | output | 16 | Per-register write enable to the register file |

## Verification
The two functions that can meet in one cycle are a register's commit and the takeover of that register by a newer writer. Directed sequences provoke this case. A load is placed behind an add and a store to the same register, so the add's commit cycle falls while the load is still in flight. A bound copy is issued so that two registers commit in the producer's final cycle. In each case the bench judges the full `rf_we` vector in those exact cycles. A behavioural model based on absolute issue times then checks `issue`, `stall`, `fwd_sel` and `rf_we` on every clock. This runs during the directed sequences and during a dense random stream over four registers, where takeovers, bound copies and hold stalls overlap freely.

// File: rtl/fp_fwd_scoreboard.sv
module fp_fwd_scoreboard #(
  parameter int NREG    = 16,
  parameter int ADD_LAT = 7,
  parameter int ADD_RDY = 6,
  parameter int MEM_LAT = 5,
  parameter int ADD_RD  = 1,
  parameter int ST_RD   = 5,
  parameter int RW      = $clog2(NREG),
  parameter int FW      = ADD_LAT - MEM_LAT + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [RW-1:0]   in_src,
  input  logic [RW-1:0]   in_dst,
  output logic            issue,
  output logic            stall,
  output logic [FW-1:0]   fwd_sel,
  output logic [NREG-1:0] rf_we
);
  localparam logic [1:0] OP_ADD = 2'd0, OP_ST = 2'd1, OP_LD = 2'd2, OP_MV = 2'd3;
  localparam int STW = $clog2(ADD_LAT + 1);
  localparam int SW  = $clog2(ADD_LAT + ST_RD + 1);
  localparam int HW  = $clog2(ST_RD);
  localparam logic [FW-1:0] SEL_RF = FW'(1) << (FW - 1);

  logic           v     [NREG];
  logic           isadd [NREG];
  logic [STW-1:0] stg   [NREG];
  logic [HW-1:0]  hold  [NREG];

  logic           s_v, s_add, rd_rf, rd_ok, alias_mv, war_ok, ok, writer;
  logic [STW-1:0] s_stg;
  logic [SW-1:0]  s_lat, s_rdy, at, s_left;

  assign s_v    = v[in_src];
  assign s_add  = isadd[in_src];
  assign s_stg  = stg[in_src];
  assign s_lat  = s_add ? SW'(ADD_LAT) : SW'(MEM_LAT);
  assign s_rdy  = s_add ? SW'(ADD_RDY) : SW'(MEM_LAT);
  assign at     = SW'(s_stg) + ((in_op == OP_ST) ? SW'(ST_RD) : SW'(ADD_RD));
  assign rd_rf  = !s_v || (at > s_lat);
  assign rd_ok  = rd_rf || (at >= s_rdy);
  assign alias_mv = (in_op == OP_MV) && s_v && (SW'(s_stg) < s_lat);
  assign s_left = s_lat - SW'(s_stg);
  assign war_ok = SW'(hold[in_dst]) <= s_left;

  always_comb begin
    case (in_op)
      OP_ADD, OP_ST: ok = rd_ok;
      OP_LD:         ok = 1'b1;
      default:       ok = !alias_mv || war_ok;
    endcase
  end

  assign issue  = in_valid && ok;
  assign stall  = in_valid && !ok;
  assign writer = issue && (in_op != OP_ST);

  always_comb begin
    fwd_sel = '0;
    if (issue) begin
      case (in_op)
        OP_ADD, OP_ST: fwd_sel = rd_rf ? SEL_RF : (FW'(1) << (at - SW'(MEM_LAT)));
        OP_MV:         fwd_sel = alias_mv ? (FW'(1) << (s_lat - SW'(MEM_LAT))) : SEL_RF;
        default:       fwd_sel = '0;
      endcase
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [STW-1:0] lat_r;
    logic           mine;
    assign lat_r    = isadd[r] ? STW'(ADD_LAT) : STW'(MEM_LAT);
    assign rf_we[r] = v[r] && (stg[r] == lat_r);
    assign mine     = writer && (in_dst == RW'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v[r]     <= 1'b0;
        isadd[r] <= 1'b0;
        stg[r]   <= '0;
        hold[r]  <= '0;
      end else begin
        if (issue && (in_op == OP_ST) && (in_src == RW'(r)))
          hold[r] <= HW'(ST_RD - 1);
        else if (hold[r] != '0)
          hold[r] <= hold[r] - HW'(1);

        if (mine) begin
          v[r]     <= 1'b1;
          isadd[r] <= alias_mv ? s_add : (in_op == OP_ADD);
          stg[r]   <= alias_mv ? (s_stg + STW'(1)) : STW'(1);
        end else if (rf_we[r]) begin
          v[r] <= 1'b0;
        end else if (v[r]) begin
          stg[r] <= stg[r] + STW'(1);
        end
      end
    end
  end
endmodule

module fp_fwd_sb_chk #(
  parameter int NREG = 16,
  parameter int FW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      in_op,
  input logic            issue,
  input logic            stall,
  input logic [FW-1:0]   fwd_sel,
  input logic [NREG-1:0] rf_we
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rf_we == '0);
  assert_store_nostall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd1) |-> issue);
  assert_load_nostall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd2) |-> issue);
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && stall));
  assert_cover_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue || stall) == in_valid);
  assert_idle_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> fwd_sel == '0);
  assert_onehot_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (in_op == 2'd0 || in_op == 2'd1)) |-> $countones(fwd_sel) == 1);
endmodule

bind fp_fwd_scoreboard fp_fwd_sb_chk #(.NREG(NREG), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .issue(issue), .stall(stall), .fwd_sel(fwd_sel), .rf_we(rf_we)
);

// File: tb/tb_fp_fwd_scoreboard.sv
module tb_fp_fwd_scoreboard;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [3:0] in_src = '0, in_dst = '0;
  logic issue, stall;
  logic [3:0] fwd_sel;
  logic [15:0] rf_we;

  fp_fwd_scoreboard dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src(in_src), .in_dst(in_dst), .issue(issue), .stall(stall),
    .fwd_sel(fwd_sel), .rf_we(rf_we));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int now = 0;
  bit mv [16];
  int mt [16], mlat [16], mrdy [16], lastrd [16];
  logic        a_iss;
  logic [3:0]  a_fwd;
  logic [15:0] a_we;
  bit          e_iss;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int op, input int s, input int d);
    int t;
    bit pend, al;
    logic [3:0] e_fwd;
    logic [15:0] e_we;
    @(negedge clk);
    in_valid = v; in_op = 2'(op); in_src = 4'(s); in_dst = 4'(d);
    #1;
    e_we = '0;
    for (int r = 0; r < 16; r++) if (mv[r] && now - mt[r] == mlat[r]) e_we[r] = 1'b1;
    pend = mv[s] && (now - mt[s] <= mlat[s]);
    e_fwd = '0; e_iss = 0; al = 0;
    if (v) begin
      case (op)
        0, 1: begin
          t = now + ((op == 1) ? 5 : 1) - mt[s];
          if (!pend || t > mlat[s]) begin e_iss = 1; e_fwd = 4'b1000; end
          else if (t >= mrdy[s]) begin e_iss = 1; e_fwd = 4'(1 << (t - 5)); end
        end
        2: e_iss = 1;
        default: begin
          al = pend && (now - mt[s] < mlat[s]);
          if (al) begin
            e_iss = lastrd[d] <= mt[s] + mlat[s];
            if (e_iss) e_fwd = 4'(1 << (mlat[s] - 5));
          end else begin
            e_iss = 1; e_fwd = 4'b1000;
          end
        end
      endcase
    end
    a_iss = issue; a_fwd = fwd_sel; a_we = rf_we;
    chk("R10 issue", 32'(issue), 32'(e_iss));
    chk("R10 stall", 32'(stall), 32'(v && !e_iss));
    chk("R11 fwd_sel", 32'(fwd_sel), 32'(e_fwd));
    chk("R6 rf_we", 32'(rf_we), 32'(e_we));
    if (e_iss) begin
      if (op == 1) lastrd[s] = now + 5;
      else if (op == 3 && al) begin
        mv[d] = 1; mt[d] = mt[s]; mlat[d] = mlat[s]; mrdy[d] = mrdy[s];
      end else begin
        mv[d] = 1; mt[d] = now; mlat[d] = (op == 0) ? 7 : 5; mrdy[d] = (op == 0) ? 6 : 5;
      end
    end
    now++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic go(input int op, input int s, input int d, output int stalls);
    stalls = 0;
    cyc(1, op, s, d);
    while (!a_iss && stalls < 20) begin
      stalls++;
      cyc(1, op, s, d);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int st;
    for (int r = 0; r < 16; r++) begin mv[r] = 0; mt[r] = 0; mlat[r] = 5; mrdy[r] = 5; lastrd[r] = -100; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: quiet after reset, unwritten source reads register file
    cyc(0, 0, 0, 0);
    chk("R1 rf_we after reset", 32'(a_we), 0);
    chk("R1 issue idle", 32'(a_iss), 0);
    go(0, 5, 12, st);
    chk("R1 unwritten source sel", 32'(a_fwd), 32'h8);
    idle(8);

    // R2 / R7: add, store, load to the same register
    go(0, 0, 1, st);
    go(1, 1, 0, st);
    chk("R2 store stalls", 32'(st), 0);
    chk("R2 store sel E6", 32'(a_fwd), 32'h2);
    idle(1);
    go(2, 0, 1, st);
    chk("R7 load stalls", 32'(st), 0);
    idle(3);
    cyc(0, 0, 0, 0);
    chk("R7 superseded add commit", 32'(a_we[1]), 0);
    cyc(0, 0, 0, 0);
    chk("R6 load commit", 32'(a_we[1]), 1);
    idle(8);

    // R3: add after add
    go(0, 0, 2, st);
    go(0, 2, 8, st);
    chk("R3 stall cycles", 32'(st), 4);
    chk("R3 sel E6", 32'(a_fwd), 32'h2);
    idle(9);

    // R4: add after load
    go(2, 0, 3, st);
    go(0, 3, 9, st);
    chk("R4 stall cycles", 32'(st), 3);
    chk("R4 sel E5", 32'(a_fwd), 32'h1);
    idle(8);

    // R8: bound copy and store of its destination
    go(0, 0, 4, st);
    go(3, 4, 5, st);
    chk("R8 copy stalls", 32'(st), 0);
    chk("R8 copy sel E7", 32'(a_fwd), 32'h4);
    go(1, 5, 0, st);
    chk("R8 store sel E7", 32'(a_fwd), 32'h4);
    idle(4);
    cyc(0, 0, 0, 0);
    chk("R8 joint commit", 32'({a_we[5], a_we[4]}), 32'h3);
    idle(8);

    // R9: copy held by an earlier store reading its destination
    go(0, 0, 7, st);
    idle(4);
    go(1, 6, 0, st);
    go(3, 7, 6, st);
    chk("R9 copy stall cycles", 32'(st), 1);
    chk("R9 unbound copy sel", 32'(a_fwd), 32'h8);
    idle(8);

    // R5: register file selection
    go(0, 10, 11, st);
    chk("R5 unwritten sel", 32'(a_fwd), 32'h8);
    go(1, 11, 0, st);
    chk("R5 store near add sel E6", 32'(a_fwd), 32'h2);
    idle(8);
    go(1, 11, 0, st);
    chk("R5 committed sel", 32'(a_fwd), 32'h8);
    idle(8);

    // Random stream, model compared every clock
    for (int i = 0; i < 600; i++)
      cyc($urandom_range(0, 9) < 8, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
    idle(10);
    finish_run();
  end
endmodule